// File: doc/BRIEF.md
# Sense-Configurable Interrupt Aggregator

This block collects up to 32 interrupt inputs and folds them into one request line. Each input can be set to level or edge sensing, and to its active sense: high or rising, or low or falling. A qualifying condition on an input sets its pending bit. Pending bits stay set until software clears them, whether or not the source is enabled. An enable word decides which pending bits reach the request output. A separate read-only word shows only the pending bits that are also enabled.

Software reaches the block through a small word-addressed port. It has an address, a write strobe, write data and combinational read data. Inputs are taken to be synchronous to the block clock already. A critical routing word is stored and read back but drives nothing. The vector offsets exist only as reserved words.

Top module: `irqc_top`

## Requirements
- R1: Source n arrives on `src_i[n]` and owns bit N_SRC-1-n of every per-source word. With the default of 32 sources, source 0 is bit 31 and source 5 is bit 26.
- R2: After reset, the enable (0x2), critical (0x3) and trigger (0x5) words are zero, the polarity word (0x4) is all ones, status (0x0) is zero and `irq_o` is low.
- R3: With the trigger bit 0 (level), the status bit is set on every clock edge at which the input sits at its active level. The active level is high when the polarity bit is 1 and low when it is 0.
- R4: With the trigger bit 1 (edge), the status bit is set when the input differs from its value at the previous clock edge. Polarity 1 takes a 0 to 1 change and polarity 0 takes a 1 to 0 change. The previous value is 0 after reset.
- R5: Writing status at offset 0x0 clears every bit written as 1 and leaves bits written as 0 untouched.
- R6: Clearing a level-sensed status bit has no effect while its input stays at the active level. This holds even when the source is disabled.
- R7: If a set event and a clear write reach the same status bit at the same edge, the bit ends up set.
- R8: Status bits latch whether or not the source is enabled.
- R9: Offset 0x6 reads status AND enable, and writes to it are ignored.
- R10: `irq_o` is high exactly when status AND enable is non-zero.
- R11: The enable, critical, polarity and trigger words read back exactly the last value written to them.
- R12: Offsets 0x1, 0x7, 0x8 and 0x9 to 0xF read as zero, and writes to them change no register.
- R13: Read data follows `addr_i` combinationally. A write takes effect at the clock edge where `we_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt inputs, index = source number |
| addr_i | input | ADDR_W | Word address of the register port |
| we_i | input | 1 | Write strobe |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults, N_SRC of 32 and ADDR_W of 4. At these values source 0 lands on bit 31, the full four-bit address space is used, and the reserved words 0x9 to 0xF can be reached. Directed sequences drive all four sense modes. They also cover clears against a level source that is still active, a clear that meets an edge at the same clock, and writes to every reserved offset. A behavioural model compares read data and the request output at every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_EN   = 2;
  localparam int unsigned OFF_CRIT = 3;
  localparam int unsigned OFF_POL  = 4;
  localparam int unsigned OFF_TRIG = 5;
  localparam int unsigned OFF_MSK  = 6;
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,   // source order
  input  logic [N-1:0] trig_i,  // register bit order
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] evt_o    // register bit order
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  for (genvar n = 0; n < N; n++) begin : g_src
    localparam int unsigned B = N - 1 - n;
    logic lvl_hit, edg_hit;
    assign lvl_hit = (src_i[n] == pol_i[B]);
    assign edg_hit = pol_i[B] ? (src_i[n] & ~prev_q[n]) : (~src_i[n] & prev_q[n]);
    assign evt_o[B] = trig_i[B] ? edg_hit : lvl_hit;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      evt_i,
  output logic [N-1:0]      stat_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      crit_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      trig_o
);
  logic [N-1:0] clr;
  logic wr_stat, wr_en, wr_crit, wr_pol, wr_trig;

  assign wr_stat = we_i && (addr_i == ADDR_W'(OFF_STAT));
  assign wr_en   = we_i && (addr_i == ADDR_W'(OFF_EN));
  assign wr_crit = we_i && (addr_i == ADDR_W'(OFF_CRIT));
  assign wr_pol  = we_i && (addr_i == ADDR_W'(OFF_POL));
  assign wr_trig = we_i && (addr_i == ADDR_W'(OFF_TRIG));
  assign clr     = wr_stat ? wdata_i : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      crit_o <= '0;
      pol_o  <= '1;
      trig_o <= '0;
    end else begin
      if (wr_en)   en_o   <= wdata_i;
      if (wr_crit) crit_o <= wdata_i;
      if (wr_pol)  pol_o  <= wdata_i;
      if (wr_trig) trig_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
  import irqc_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      stat_i,
  input  logic [N-1:0]      en_i,
  input  logic [N-1:0]      crit_i,
  input  logic [N-1:0]      pol_i,
  input  logic [N-1:0]      trig_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      msk_o
);
  assign msk_o = stat_i & en_i;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = stat_i;
    if (addr_i == ADDR_W'(OFF_EN))   rdata_o = en_i;
    if (addr_i == ADDR_W'(OFF_CRIT)) rdata_o = crit_i;
    if (addr_i == ADDR_W'(OFF_POL))  rdata_o = pol_i;
    if (addr_i == ADDR_W'(OFF_TRIG)) rdata_o = trig_i;
    if (addr_i == ADDR_W'(OFF_MSK))  rdata_o = msk_o;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] evt, stat_q, en_q, crit_q, pol_q, trig_q, msk;

  irqc_sense #(.N(N_SRC)) u_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .trig_i(trig_q),
    .pol_i (pol_q),
    .evt_o (evt)
  );

  irqc_regs #(.N(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .evt_i  (evt),
    .stat_o (stat_q),
    .en_o   (en_q),
    .crit_o (crit_q),
    .pol_o  (pol_q),
    .trig_o (trig_q)
  );

  irqc_rdmux #(.N(N_SRC), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i (addr_i),
    .stat_i (stat_q),
    .en_i   (en_q),
    .crit_i (crit_q),
    .pol_i  (pol_q),
    .trig_i (trig_q),
    .rdata_o(rdata_o),
    .msk_o  (msk)
  );

  assign irq_o = |msk;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      src_i,
  input logic              irq_o,
  input logic [N-1:0]      evt,
  input logic [N-1:0]      stat_q,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      crit_q,
  input logic [N-1:0]      pol_q,
  input logic [N-1:0]      trig_q
);
  logic [N-1:0] src_reg, lvl_act;
  logic         rsvd_wr;

  always_comb begin
    for (int n = 0; n < N; n++) src_reg[N-1-n] = src_i[n];
  end
  assign lvl_act = ~trig_q & ~(src_reg ^ pol_q);
  assign rsvd_wr = we_i && !(addr_i == ADDR_W'(OFF_STAT) || addr_i == ADDR_W'(OFF_EN) ||
                   addr_i == ADDR_W'(OFF_CRIT) || addr_i == ADDR_W'(OFF_POL) ||
                   addr_i == ADDR_W'(OFF_TRIG));

  // R5
  a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_STAT)) |=> ((stat_q & $past(wdata_i & ~evt)) == '0));

  // R7
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

  // R6
  a_r6_level_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(lvl_act)) == $past(lvl_act)));

  // R10
  a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  // R12
  a_r12_reserved_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_wr |=> ($stable(en_q) && $stable(crit_q) && $stable(pol_q) && $stable(trig_q)));

  // R11
  a_r11_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFF_EN)) |=> $stable(en_q));
endmodule

bind irqc_top irqc_chk #(.N(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .src_i  (src_i),
  .irq_o  (irq_o),
  .evt    (evt),
  .stat_q (stat_q),
  .en_q   (en_q),
  .crit_q (crit_q),
  .pol_q  (pol_q),
  .trig_q (trig_q)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  irqc_top u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference model
  bit [31:0] m_stat, m_en, m_crit, m_pol, m_trig, m_prev;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat = 0; m_en = 0; m_crit = 0; m_pol = '1; m_trig = 0; m_prev = 0;
    end else begin
      bit [31:0] ev;
      for (int n = 0; n < 32; n++) begin
        int b;
        b = 31 - n;
        if (m_trig[b])
          ev[b] = m_pol[b] ? (src_i[n] && !m_prev[n]) : (!src_i[n] && m_prev[n]);
        else
          ev[b] = (src_i[n] == m_pol[b]);
      end
      if (we_i) begin
        case (addr_i)
          4'h0: m_stat = m_stat & ~wdata_i;
          4'h2: m_en = wdata_i;
          4'h3: m_crit = wdata_i;
          4'h4: m_pol = wdata_i;
          4'h5: m_trig = wdata_i;
          default: ;
        endcase
      end
      m_stat = m_stat | ev;
      m_prev = src_i;
    end
  end

  function automatic bit [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return m_stat;
      4'h2: return m_en;
      4'h3: return m_crit;
      4'h4: return m_pol;
      4'h5: return m_trig;
      4'h6: return m_stat & m_en;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0: return "R5";
      4'h2, 4'h3, 4'h4, 4'h5: return "R11";
      4'h6: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock; model compare happens after the edge, away from it (R13)
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    check(rdata_o, m_read(addr_i), tag_of(addr_i));
    check({31'b0, irq_o}, {31'b0, |(m_stat & m_en)}, "R10");
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    step();
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr_i = a; we_i = 1'b0;
    step();
    check(rdata_o, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 reset state
    rd(4'h2, 32'h0, "R2");
    rd(4'h3, 32'h0, "R2");
    rd(4'h5, 32'h0, "R2");
    rd(4'h4, 32'hFFFF_FFFF, "R2");
    rd(4'h0, 32'h0, "R2");
    check({31'b0, irq_o}, 32'h0, "R2");
    // R1 / R3 level high, R8 latch while disabled
    src_i[0] = 1'b1; src_i[5] = 1'b1;
    rd(4'h0, 32'h8400_0000, "R1");
    check({31'b0, irq_o}, 32'h0, "R8");
    wr(4'h2, 32'h8000_0000);
    rd(4'h6, 32'h8000_0000, "R9");
    check({31'b0, irq_o}, 32'h1, "R10");
    // R6 clear while level still active
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h8400_0000, "R6");
    // R5 clear once inputs drop, and partial clear
    src_i[0] = 1'b0; src_i[5] = 1'b0;
    wr(4'h0, 32'h0400_0000);
    rd(4'h0, 32'h8000_0000, "R5");
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0, "R5");
    check({31'b0, irq_o}, 32'h0, "R10");
    // R4 rising edge
    wr(4'h5, 32'hFFFF_FFFF);
    src_i[3] = 1'b1;
    rd(4'h0, 32'h1000_0000, "R4");
    wr(4'h0, 32'h1000_0000);
    rd(4'h0, 32'h0, "R4");
    // R4 falling edge
    wr(4'h4, 32'hEFFF_FFFF);
    src_i[3] = 1'b0;
    rd(4'h0, 32'h1000_0000, "R4");
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0, "R4");
    // R7 edge and clear at the same edge
    src_i[7] = 1'b1;
    wr(4'h0, 32'h0100_0000);
    rd(4'h0, 32'h0100_0000, "R7");
    wr(4'h0, 32'h0100_0000);
    rd(4'h0, 32'h0, "R7");
    // R3 level low on source 0
    wr(4'h5, 32'h7FFF_FFFF);
    wr(4'h4, 32'h6FFF_FFFF);
    rd(4'h0, 32'h8000_0000, "R3");
    check({31'b0, irq_o}, 32'h1, "R10");
    // R12 reserved offsets
    for (int a = 7; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), 32'h0, "R12");
    end
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, 32'h0, "R12");
    wr(4'h6, 32'h0);
    rd(4'h6, 32'h8000_0000, "R9");
    rd(4'h2, 32'h8000_0000, "R12");
    rd(4'h5, 32'h7FFF_FFFF, "R12");
    // R11 read back
    wr(4'h3, 32'hA5A5_0F0F);
    rd(4'h3, 32'hA5A5_0F0F, "R11");
    rd(4'h4, 32'h6FFF_FFFF, "R11");
    wr(4'h2, 32'h0);
    rd(4'h2, 32'h0, "R11");
    check({31'b0, irq_o}, 32'h0, "R10");
    repeat (4) step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule